// File: doc/BRIEF.md
# Write-Once Snooping Coherence Controller

This block is the coherence engine for one processor's private direct-mapped cache on a shared snooping bus. Each line holds one word and is in one of four states: Invalid, Valid (clean, possibly shared), Reserved (clean, written through exactly once, no other copy) and Dirty (modified, sole copy). The first processor write to a Valid line goes through to memory as a bus write. That write also invalidates every other copy and moves the line to Reserved. Later writes stay local and leave the line Dirty.

On the processor side a request is held on `cpu_req_i` until `cpu_ready_o` pulses for one cycle. Hits finish in the cycle of the request. Misses and write-throughs raise `bus_req_o` and wait for `bus_gnt_i`. A granted cycle is the bus transaction: command, address and data are driven in that cycle, and a fill takes `bus_din_i` in that same cycle. Addresses are word addresses. The low three bits pick the line and the remaining bits form the tag. Bus commands by other controllers arrive on the snoop inputs, one per cycle. The controller answers a snooped read of a Dirty line by driving `snp_flush_o` and the line data in that same cycle.

Top module: `wo_coherence_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready_o`, `bus_req_o` and `snp_flush_o` are low, and the first read of any address misses.
- R2: A read miss raises `bus_req_o`. In the granted cycle the block drives command 2'b01 with the request address, takes `bus_din_i` as read data, pulses `cpu_ready_o` and fills the line as Valid.
- R3: A read that hits a Valid, Reserved or Dirty line completes in the request cycle with the stored word and no bus request.
- R4: A write that hits a Valid line requests the bus. In the granted cycle it drives command 2'b11 with the address and write data, completes, and the line becomes Reserved.
- R5: A write that hits a Reserved or Dirty line completes in the request cycle with no bus request, and the line becomes or stays Dirty.
- R6: A write miss drives command 2'b10 with the request address in its granted cycle, stores the write data and marks the line Dirty.
- R7: A miss whose index holds a Dirty line of another tag first writes that line back (command 2'b11, old address, old data) in one granted cycle, then fills in a second one. A Valid or Reserved victim is dropped with no write-back.
- R8: A snooped read (2'b01) that hits a Dirty line raises `snp_flush_o` with the line data in that cycle, and the line becomes Valid. A snooped read that hits a Reserved line makes it Valid without a flush.
- R9: A snooped read-invalidate (2'b10) or write (2'b11) that hits a line makes it Invalid. A read-invalidate that hits a Dirty line also flushes its data.
- R10: The state of a pending write is re-examined in the granted cycle. If a snoop invalidated the Valid line while the write waited, the write is issued as a read-invalidate (2'b10) and the line ends Dirty.
- R11: In a cycle where a snoop targets the same index as the pending processor request, the processor side neither completes nor requests the bus.
- R12: A snoop whose tag does not match the resident line leaves that line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req_i | input | 1 | Processor request, held until ready |
| cpu_we_i | input | 1 | 1 for write, 0 for read |
| cpu_addr_i | input | 32 | Word address of the request |
| cpu_wdata_i | input | 32 | Write data |
| cpu_ready_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | 32 | Read data, valid with ready on reads |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant; a granted cycle carries one transaction |
| bus_cmd_o | output | 2 | Bus command: 00 idle, 01 read, 10 read-invalidate, 11 write |
| bus_addr_o | output | 32 | Bus address |
| bus_data_o | output | 32 | Bus write data |
| bus_din_i | input | 32 | Memory data returned in the granted cycle |
| snp_cmd_i | input | 2 | Command seen from another controller |
| snp_addr_i | input | 32 | Address seen from another controller |
| snp_flush_o | output | 1 | This cache supplies data for the snooped command |
| snp_data_o | output | 32 | Supplied line data |

## Verification
The bench targets the three transitions that tell write-once apart from plain MSI. These are the write-through on the first write to a Valid line, the local absorb on Reserved, and the drop from Reserved or Dirty back to Valid on a snooped read. A design that treated Reserved as Dirty would skip the write-through and fail the bus scoreboard. It also covers dirty-victim eviction, where a missing write-back would show as a fill with no preceding 2'b11 transfer. It checks the race where an invalidate lands while a write waits for the grant: a design that decided the command early would send 2'b11 for a line it no longer holds. Snoops with the same index but a different tag, and snoops that collide with a pending request, check that unrelated lines keep their state and that the processor side stalls.

// File: rtl/wo_pkg.sv
package wo_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_VAL = 2'b01,
    LS_RES = 2'b10,
    LS_DRT = 2'b11
  } line_st_e;

  typedef enum logic [1:0] {
    BC_IDLE = 2'b00,
    BC_RD   = 2'b01,
    BC_RDX  = 2'b10,
    BC_WR   = 2'b11
  } bus_cmd_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_LOCAL,
    OP_WB,
    OP_WT,
    OP_FILL,
    OP_FILLX
  } op_e;
endpackage

// File: rtl/wo_line_store.sv
module wo_line_store
  import wo_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int TAG_W  = 29,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  c_idx,
  input  logic              c_we,
  input  line_st_e          c_st,
  input  logic              c_tag_we,
  input  logic [TAG_W-1:0]  c_tag,
  input  logic              c_data_we,
  input  logic [DATA_W-1:0] c_data,
  input  logic [IDX_W-1:0]  s_idx,
  input  logic              s_we,
  input  line_st_e          s_st,
  output line_st_e          c_st_o,
  output logic [TAG_W-1:0]  c_tag_o,
  output logic [DATA_W-1:0] c_data_o,
  output line_st_e          s_st_o,
  output logic [TAG_W-1:0]  s_tag_o,
  output logic [DATA_W-1:0] s_data_o
);
  line_st_e          st_arr  [LINES];
  logic [TAG_W-1:0]  tag_arr [LINES];
  logic [DATA_W-1:0] dat_arr [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    line_st_e          st_q, st_d;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] dat_q;
    logic              s_sel, c_sel;

    always_comb begin
      s_sel = s_we && (s_idx == IDX_W'(i));
      c_sel = c_we && (c_idx == IDX_W'(i));
      st_d  = st_q;
      if (s_sel)      st_d = s_st;
      else if (c_sel) st_d = c_st;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= LS_INV;
      else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
      if (c_sel && c_tag_we)  tag_q <= c_tag;
      if (c_sel && c_data_we) dat_q <= c_data;
    end

    assign st_arr[i]  = st_q;
    assign tag_arr[i] = tag_q;
    assign dat_arr[i] = dat_q;

    // R9
    snoop_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_sel && s_st == LS_INV) |=> (st_q == LS_INV));
  end

  assign c_st_o   = st_arr[c_idx];
  assign c_tag_o  = tag_arr[c_idx];
  assign c_data_o = dat_arr[c_idx];
  assign s_st_o   = st_arr[s_idx];
  assign s_tag_o  = tag_arr[s_idx];
  assign s_data_o = dat_arr[s_idx];
endmodule

// File: rtl/wo_snoop_unit.sv
module wo_snoop_unit
  import wo_pkg::*;
#(
  parameter int TAG_W  = 29,
  parameter int DATA_W = 32
) (
  input  bus_cmd_e          cmd,
  input  logic [TAG_W-1:0]  tag,
  input  line_st_e          st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              s_we,
  output line_st_e          s_st,
  output logic              flush,
  output logic [DATA_W-1:0] flush_data
);
  logic hit;

  always_comb begin
    hit  = (cmd != BC_IDLE) && (st != LS_INV) && (line_tag == tag);
    s_st = st;
    unique case (cmd)
      BC_RD:         s_st = (st == LS_DRT || st == LS_RES) ? LS_VAL : st;
      BC_RDX, BC_WR: s_st = LS_INV;
      default:       s_st = st;
    endcase
    s_we       = hit && (s_st != st);
    flush      = hit && (st == LS_DRT) && (cmd != BC_WR);
    flush_data = line_data;
  end
endmodule

// File: rtl/wo_req_seq.sv
module wo_req_seq
  import wo_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              stall,
  input  line_st_e          st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  input  logic              gnt,
  input  logic [DATA_W-1:0] din,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              breq,
  output bus_cmd_e          bcmd,
  output logic [ADDR_W-1:0] baddr,
  output logic [DATA_W-1:0] bdata,
  output logic              c_we,
  output line_st_e          c_st,
  output logic              c_tag_we,
  output logic              c_data_we,
  output logic [DATA_W-1:0] c_data
);
  op_e  op;
  logic hit, go;

  always_comb begin
    hit = (st != LS_INV) && (line_tag == addr[ADDR_W-1:IDX_W]);
    if (!req || stall)             op = OP_NONE;
    else if (hit)                  op = (!we || st != LS_VAL) ? OP_LOCAL : OP_WT;
    else if (st == LS_DRT)         op = OP_WB;
    else                           op = we ? OP_FILLX : OP_FILL;

    breq  = op inside {OP_WB, OP_WT, OP_FILL, OP_FILLX};
    go    = breq && gnt;
    ready = (op == OP_LOCAL) || (go && op != OP_WB);
    rdata = (op == OP_FILL) ? din : line_data;

    c_we      = ((op == OP_LOCAL) && we) || go;
    c_tag_we  = go && (op == OP_FILL || op == OP_FILLX);
    c_data_we = c_we && (op != OP_WB);
    c_data    = (op == OP_FILL) ? din : wdata;
    unique case (op)
      OP_LOCAL: c_st = LS_DRT;
      OP_WT:    c_st = LS_RES;
      OP_FILL:  c_st = LS_VAL;
      OP_FILLX: c_st = LS_DRT;
      default:  c_st = LS_INV;
    endcase

    bcmd  = BC_IDLE;
    baddr = '0;
    bdata = '0;
    if (go) begin
      unique case (op)
        OP_WB: begin
          bcmd  = BC_WR;
          baddr = {line_tag, addr[IDX_W-1:0]};
          bdata = line_data;
        end
        OP_WT: begin
          bcmd  = BC_WR;
          baddr = addr;
          bdata = wdata;
        end
        OP_FILL: begin
          bcmd  = BC_RD;
          baddr = addr;
        end
        default: begin
          bcmd  = BC_RDX;
          baddr = addr;
        end
      endcase
    end
  end
endmodule

// File: rtl/wo_coherence_ctrl.sv
module wo_coherence_ctrl
  import wo_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic [DATA_W-1:0] bus_din_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_flush_o,
  output logic [DATA_W-1:0] snp_data_o
);
  logic [1:0] rs_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q_n = rs_q[1];

  bus_cmd_e          snp_cmd, bcmd;
  logic [IDX_W-1:0]  c_idx, s_idx;
  line_st_e          c_st_r, s_st_r, c_st_w, s_st_w;
  logic [TAG_W-1:0]  c_tag_r, s_tag_r;
  logic [DATA_W-1:0] c_data_r, s_data_r, c_data_w;
  logic              c_we, c_tag_we, c_data_we, s_we, stall, c_hit;

  assign snp_cmd   = bus_cmd_e'(snp_cmd_i);
  assign c_idx     = cpu_addr_i[IDX_W-1:0];
  assign s_idx     = snp_addr_i[IDX_W-1:0];
  assign stall     = (snp_cmd != BC_IDLE) && (s_idx == c_idx);
  assign c_hit     = (c_st_r != LS_INV) && (c_tag_r == cpu_addr_i[ADDR_W-1:IDX_W]);
  assign bus_cmd_o = bcmd;

  wo_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_q_n),
    .c_idx(c_idx), .c_we(c_we), .c_st(c_st_w), .c_tag_we(c_tag_we),
    .c_tag(cpu_addr_i[ADDR_W-1:IDX_W]), .c_data_we(c_data_we), .c_data(c_data_w),
    .s_idx(s_idx), .s_we(s_we), .s_st(s_st_w),
    .c_st_o(c_st_r), .c_tag_o(c_tag_r), .c_data_o(c_data_r),
    .s_st_o(s_st_r), .s_tag_o(s_tag_r), .s_data_o(s_data_r)
  );

  wo_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .cmd(snp_cmd), .tag(snp_addr_i[ADDR_W-1:IDX_W]), .st(s_st_r),
    .line_tag(s_tag_r), .line_data(s_data_r),
    .s_we(s_we), .s_st(s_st_w), .flush(snp_flush_o), .flush_data(snp_data_o)
  );

  wo_req_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_seq (
    .req(cpu_req_i && rst_q_n), .we(cpu_we_i), .addr(cpu_addr_i), .wdata(cpu_wdata_i),
    .stall(stall), .st(c_st_r), .line_tag(c_tag_r), .line_data(c_data_r),
    .gnt(bus_gnt_i), .din(bus_din_i),
    .ready(cpu_ready_o), .rdata(cpu_rdata_o), .breq(bus_req_o), .bcmd(bcmd),
    .baddr(bus_addr_o), .bdata(bus_data_o),
    .c_we(c_we), .c_st(c_st_w), .c_tag_we(c_tag_we), .c_data_we(c_data_we),
    .c_data(c_data_w)
  );

  // R4
  first_write_bus_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cpu_ready_o && cpu_we_i && c_hit && c_st_r == LS_VAL) |-> (bus_cmd_o == 2'b11));

  // R5
  local_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cpu_ready_o && c_hit && (!cpu_we_i || c_st_r != LS_VAL)) |-> !bus_req_o);

  // R7
  no_dirty_drop_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_cmd_o == 2'b01 || bus_cmd_o == 2'b10) |-> !(c_st_r == LS_DRT && !c_hit));

  // R11
  snoop_stall_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    stall |-> (!cpu_ready_o && !bus_req_o));
endmodule

// File: tb/wo_coherence_ctrl_bench.sv
module wo_coherence_ctrl_bench;
  localparam logic [31:0] MEMK = 32'h5A00_0000;
  localparam int KB = 0, KC = 1, KF = 2;

  typedef struct {
    int          kind;
    logic [1:0]  cmd;
    logic [31:0] addr;
    logic [31:0] data;
    bit          chk;
    string       rq;
  } exp_t;

  logic        clk = 0, rst_n = 0;
  logic        cpu_req = 0, cpu_we = 0, bus_gnt = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0, bus_din = 0, snp_addr = 0;
  logic [1:0]  snp_cmd = 0;
  logic        cpu_ready_o, bus_req_o, snp_flush_o;
  logic [31:0] cpu_rdata_o, bus_addr_o, bus_data_o, snp_data_o;
  logic [1:0]  bus_cmd_o;

  int   total = 0, bad = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  wo_coherence_ctrl u_wo_coherence_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ready_o(cpu_ready_o), .cpu_rdata_o(cpu_rdata_o),
    .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt), .bus_cmd_o(bus_cmd_o),
    .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o), .bus_din_i(bus_din),
    .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .snp_flush_o(snp_flush_o), .snp_data_o(snp_data_o)
  );

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
    end
  endtask

  task automatic push(input int k, input logic [1:0] c, input logic [31:0] a,
                      input logic [31:0] d, input bit chk, input string rq);
    exp_t e;
    e.kind = k; e.cmd = c; e.addr = a; e.data = d; e.chk = chk; e.rq = rq;
    q.push_back(e);
  endtask

  task automatic pop_cmp(input int k, input logic [1:0] c, input logic [31:0] a, input logic [31:0] d);
    exp_t e;
    if (q.size() == 0) begin
      check(0, "unexpected event", 32'(k), 32'hFFFF_FFFF);
      return;
    end
    e = q.pop_front();
    check(e.kind == k, e.rq, 32'(k), 32'(e.kind));
    if (k == KB) begin
      check(c == e.cmd, e.rq, 32'(c), 32'(e.cmd));
      check(a == e.addr, e.rq, a, e.addr);
    end
    if (e.chk) check(d == e.data, e.rq, d, e.data);
  endtask

  // monitor: samples 5 ns after the falling edge
  always begin
    @(negedge clk);
    #5;
    if (rst_n) begin
      if (bus_cmd_o != 2'b00) pop_cmp(KB, bus_cmd_o, bus_addr_o, bus_data_o);
      if (snp_flush_o)        pop_cmp(KF, 2'b00, 32'h0, snp_data_o);
      if (cpu_ready_o)        pop_cmp(KC, 2'b00, 32'h0, cpu_rdata_o);
    end
  end

  task automatic cpu_op(input bit we, input logic [31:0] a, input logic [31:0] d,
                        input int want_lat, input string rq);
    int lat;
    bit done, want;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d; bus_din = a ^ MEMK; bus_gnt = 0;
    lat = 0;
    for (int c = 0; c < 40; c++) begin
      #5;
      done = cpu_ready_o;
      want = bus_req_o;
      @(negedge clk);
      if (done) begin
        lat = c + 1;
        break;
      end
      bus_gnt = want && !bus_gnt;
    end
    cpu_req = 0; bus_gnt = 0;
    if (want_lat > 0) check(lat == want_lat, rq, 32'(lat), 32'(want_lat));
  endtask

  task automatic snoop(input logic [1:0] c, input logic [31:0] a);
    @(negedge clk);
    snp_cmd = c; snp_addr = a;
    @(negedge clk);
    snp_cmd = 0; snp_addr = 0;
  endtask

  initial begin
    #(20 * 100000);
    check(0, "watchdog", 32'h0, 32'h1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] a, b, c3, d4, e5;
    a = 32'h100; b = 32'h201; c3 = 32'h309; d4 = 32'h411; e5 = 32'h0A2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #5;
    // R1: quiet after reset
    check(!cpu_ready_o && !bus_req_o && !snp_flush_o, "R1", {bus_req_o, cpu_ready_o}, 0);

    // R1, R2: first read misses, bus read, fill
    push(KB, 2'b01, a, 0, 1, "R2");
    push(KC, 2'b00, 0, a ^ MEMK, 1, "R2");
    cpu_op(0, a, 0, 2, "R2");
    // R3: read hit on Valid
    push(KC, 2'b00, 0, a ^ MEMK, 1, "R3");
    cpu_op(0, a, 0, 1, "R3");
    // R4: first write writes through
    push(KB, 2'b11, a, 32'h1111, 1, "R4");
    push(KC, 2'b00, 0, 0, 0, "R4");
    cpu_op(1, a, 32'h1111, 2, "R4");
    // R5: second write absorbed locally
    push(KC, 2'b00, 0, 0, 0, "R5");
    cpu_op(1, a, 32'h2222, 1, "R5");
    push(KC, 2'b00, 0, 32'h2222, 1, "R3");
    cpu_op(0, a, 0, 1, "R3");
    // R8: snooped read of Dirty flushes, line Valid
    push(KF, 2'b00, 0, 32'h2222, 1, "R8");
    snoop(2'b01, a);
    push(KB, 2'b11, a, 32'h3333, 1, "R8");
    push(KC, 2'b00, 0, 0, 0, "R8");
    cpu_op(1, a, 32'h3333, 2, "R8");
    // R8: snooped read of Reserved, no flush, line Valid
    snoop(2'b01, a);
    push(KB, 2'b11, a, 32'h4444, 1, "R8");
    push(KC, 2'b00, 0, 0, 0, "R8");
    cpu_op(1, a, 32'h4444, 2, "R8");
    // R9: snooped read-invalidate on Dirty flushes and invalidates
    push(KC, 2'b00, 0, 0, 0, "R5");
    cpu_op(1, a, 32'h5555, 1, "R5");
    push(KF, 2'b00, 0, 32'h5555, 1, "R9");
    snoop(2'b10, a);
    push(KB, 2'b01, a, 0, 1, "R9");
    push(KC, 2'b00, 0, a ^ MEMK, 1, "R9");
    cpu_op(0, a, 0, 2, "R9");
    // R6: write miss
    push(KB, 2'b10, b, 0, 1, "R6");
    push(KC, 2'b00, 0, 0, 0, "R6");
    cpu_op(1, b, 32'hBBBB, 2, "R6");
    push(KC, 2'b00, 0, 32'hBBBB, 1, "R6");
    cpu_op(0, b, 0, 1, "R6");
    // R7: Dirty victim written back, then fill
    push(KB, 2'b11, b, 32'hBBBB, 1, "R7");
    push(KB, 2'b01, c3, 0, 1, "R7");
    push(KC, 2'b00, 0, c3 ^ MEMK, 1, "R7");
    cpu_op(0, c3, 0, 4, "R7");
    // R7: Valid victim dropped silently
    push(KB, 2'b01, d4, 0, 1, "R7");
    push(KC, 2'b00, 0, d4 ^ MEMK, 1, "R7");
    cpu_op(0, d4, 0, 2, "R7");
    // R12: snoop with other tag ignored
    snoop(2'b11, 32'h511);
    push(KC, 2'b00, 0, d4 ^ MEMK, 1, "R12");
    cpu_op(0, d4, 0, 1, "R12");
    // R9: snooped write invalidates
    snoop(2'b11, d4);
    push(KB, 2'b01, d4, 0, 1, "R9");
    push(KC, 2'b00, 0, d4 ^ MEMK, 1, "R9");
    cpu_op(0, d4, 0, 2, "R9");
    // R10, R11: invalidate lands while a write waits for the bus
    push(KB, 2'b01, e5, 0, 1, "R10");
    push(KC, 2'b00, 0, e5 ^ MEMK, 1, "R10");
    cpu_op(0, e5, 0, 2, "R10");
    push(KB, 2'b10, e5, 0, 1, "R10");
    push(KC, 2'b00, 0, 0, 0, "R10");
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = e5; cpu_wdata = 32'hEEEE; bus_din = e5 ^ MEMK;
    #5;
    check(bus_req_o && !cpu_ready_o, "R10", {bus_req_o, cpu_ready_o}, 32'h2);
    @(negedge clk);
    snp_cmd = 2'b11; snp_addr = e5;
    #5;
    check(!bus_req_o && !cpu_ready_o, "R11", {bus_req_o, cpu_ready_o}, 32'h0);
    @(negedge clk);
    snp_cmd = 0; snp_addr = 0; bus_gnt = 1;
    #5;
    check(cpu_ready_o, "R10", 32'(cpu_ready_o), 32'h1);
    @(negedge clk);
    bus_gnt = 0; cpu_req = 0;
    push(KC, 2'b00, 0, 32'hEEEE, 1, "R10");
    cpu_op(0, e5, 0, 1, "R10");

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R2 scoreboard drained", 32'(q.size()), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule